// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O port of `NPIN` pins (32 by default) sitting on a simple register bus made of an address, a write strobe, write data and a combinational read-data return. Software drives pins through an output latch and a per-pin drive-enable register, and observes them through a synchronised pad-level register.

Every pin carries its own interrupt detector. A two-bit trigger code selects low level, high level, rising edge or falling edge. A separate both-edges bit overrides that code. Detections latch into a status register that software clears by writing ones. The status, gated by a mask register, is reduced onto two interrupt lines: one for the lower half of the pins and one for the upper half.

Pad inputs first cross a synchroniser of `SYNC_STAGES` flops. Edges are found by comparing the synchronised level with its value one cycle earlier. Level triggers keep setting their status bit on every cycle the level is present.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers sit at byte addresses 0x00 output latch, 0x04 drive enable, 0x08 pad level (read only), 0x0C trigger codes for the lower half, 0x10 trigger codes for the upper half, 0x14 mask, 0x18 status and 0x1C both-edges select. Writable registers read back what was written, and any other address reads zero.
- R2: `pad_out` always equals the output latch, and `pad_oe` bit n is 1 (pin driven) exactly when drive-enable bit n is 1.
- R3: The pad-level register returns `pad_in` delayed by the synchroniser. With the default two stages, a change applied before clock edge k reads back after edge k+1 and not after edge k.
- R4: Pin p takes its two-bit trigger code from bits [2*(p mod 16)+1 : 2*(p mod 16)], in the lower-half register for p < 16 and in the upper-half register otherwise.
- R5: Trigger code 0 detects a low level, 1 a high level, 2 a rising edge and 3 a falling edge. An edge on `pad_in` applied before edge k sets its status bit after edge k+2. An edge of the opposite direction sets nothing.
- R6: When a pin's both-edges bit is 1, the pin detects rising and falling edges whatever its trigger code holds.
- R7: Writing 1 to a status bit clears it, writing 0 leaves it as it is, and writing all ones clears every bit that has no detection in that cycle.
- R8: A level trigger sets its status bit on every cycle the synchronised level matches, so clearing it while the level persists leaves it set.
- R9: When a clear and a new detection hit the same status bit in the same cycle, the bit stays set.
- R10: `irq_lo` is 1 while any status bit of pins 0 to NPIN/2-1 is set with its mask bit 1. `irq_hi` does the same for the upper pins. Neither line is affected by the other half.
- R11: Reset clears the output latch, drive enable, both trigger registers, mask, status and both-edges select, so all pins start as inputs and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data for `bus_addr`, combinational |
| pad_in | input | NPIN | Pad input levels, asynchronous |
| pad_out | output | NPIN | Output latch driven towards the pads |
| pad_oe | output | NPIN | Per-pin drive enable, 1 = output |
| irq_lo | output | 1 | Interrupt for the lower half of the pins |
| irq_hi | output | 1 | Interrupt for the upper half of the pins |

## Verification
A wrong trigger decode or a misplaced code field shows up as a status bit that fails to set, or sets on the wrong pin. This is visible at the status read three cycles after the pad moves, and at once on an interrupt line when that pin is unmasked. A lost clear priority or a sticky-bit error shows up in the status read one cycle after the clearing write. A synchroniser of the wrong depth shifts the pad-level read by a cycle, which the bench catches by sampling both before and after the expected edge. A wrong half split shows as the wrong interrupt line rising while only one pin is unmasked.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // register byte offsets
   localparam int OFF_DATA  = 'h00;
   localparam int OFF_DIR   = 'h04;
   localparam int OFF_PAD   = 'h08;
   localparam int OFF_CFGL  = 'h0C;
   localparam int OFF_CFGH  = 'h10;
   localparam int OFF_MASK  = 'h14;
   localparam int OFF_STAT  = 'h18;
   localparam int OFF_BOTH  = 'h1C;

   localparam int MAX_PINS  = 32;
   localparam int TRIG_W    = 2;

   typedef enum logic [TRIG_W-1:0] {
      TRIG_LOW  = 2'd0,
      TRIG_HIGH = 2'd1,
      TRIG_RISE = 2'd2,
      TRIG_FALL = 2'd3
   } trig_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) begin
            stage_q[s] <= '0;
         end
         prev_q <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
         prev_q <= stage_q[STAGES-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
   assign prev_o = prev_q;

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
   import gpio_irq_pkg::*;
#(
   parameter int NPIN = 32
) (
   input  logic [NPIN-1:0] sync_i,
   input  logic [NPIN-1:0] prev_i,
   input  logic [NPIN-1:0] cfg_lo_i,
   input  logic [NPIN-1:0] cfg_hi_i,
   input  logic [NPIN-1:0] both_i,
   output logic [NPIN-1:0] hit_o
);

   localparam int HALF = NPIN / 2;

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic [TRIG_W-1:0] code;
      logic              rise;
      logic              fall;

      if (p < HALF) begin : g_lo
         assign code = cfg_lo_i[TRIG_W*p +: TRIG_W];
      end else begin : g_hi
         assign code = cfg_hi_i[TRIG_W*(p-HALF) +: TRIG_W];
      end

      assign rise = sync_i[p] & ~prev_i[p];
      assign fall = ~sync_i[p] & prev_i[p];

      always_comb begin
         if (both_i[p]) begin
            hit_o[p] = rise | fall;
         end else begin
            unique case (trig_e'(code))
               TRIG_LOW:  hit_o[p] = ~sync_i[p];
               TRIG_HIGH: hit_o[p] = sync_i[p];
               TRIG_RISE: hit_o[p] = rise;
               TRIG_FALL: hit_o[p] = fall;
               default:   hit_o[p] = 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_irq_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPIN-1:0]   bus_wdata,
   output logic [NPIN-1:0]   bus_rdata,
   input  logic [NPIN-1:0]   pad_lvl_i,
   input  logic [NPIN-1:0]   hit_i,
   output logic [NPIN-1:0]   data_q,
   output logic [NPIN-1:0]   dir_q,
   output logic [NPIN-1:0]   cfg_lo_q,
   output logic [NPIN-1:0]   cfg_hi_q,
   output logic [NPIN-1:0]   mask_q,
   output logic [NPIN-1:0]   both_q,
   output logic [NPIN-1:0]   stat_q
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
   localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'(OFF_PAD);
   localparam logic [ADDR_W-1:0] A_CFGL = ADDR_W'(OFF_CFGL);
   localparam logic [ADDR_W-1:0] A_CFGH = ADDR_W'(OFF_CFGH);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(OFF_BOTH);

   logic            wr_data, wr_dir, wr_cfgl, wr_cfgh, wr_mask, wr_stat, wr_both;
   logic [NPIN-1:0] clr_bits;

   assign wr_data = bus_we && (bus_addr == A_DATA);
   assign wr_dir  = bus_we && (bus_addr == A_DIR);
   assign wr_cfgl = bus_we && (bus_addr == A_CFGL);
   assign wr_cfgh = bus_we && (bus_addr == A_CFGH);
   assign wr_mask = bus_we && (bus_addr == A_MASK);
   assign wr_stat = bus_we && (bus_addr == A_STAT);
   assign wr_both = bus_we && (bus_addr == A_BOTH);

   assign clr_bits = wr_stat ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         dir_q    <= '0;
         cfg_lo_q <= '0;
         cfg_hi_q <= '0;
         mask_q   <= '0;
         both_q   <= '0;
         stat_q   <= '0;
      end else begin
         if (wr_data) data_q   <= bus_wdata;
         if (wr_dir)  dir_q    <= bus_wdata;
         if (wr_cfgl) cfg_lo_q <= bus_wdata;
         if (wr_cfgh) cfg_hi_q <= bus_wdata;
         if (wr_mask) mask_q   <= bus_wdata;
         if (wr_both) both_q   <= bus_wdata;
         // a detection in the clearing cycle takes priority
         stat_q <= (stat_q & ~clr_bits) | hit_i;
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_DATA:  bus_rdata = data_q;
         A_DIR:   bus_rdata = dir_q;
         A_PAD:   bus_rdata = pad_lvl_i;
         A_CFGL:  bus_rdata = cfg_lo_q;
         A_CFGH:  bus_rdata = cfg_hi_q;
         A_MASK:  bus_rdata = mask_q;
         A_STAT:  bus_rdata = stat_q;
         A_BOTH:  bus_rdata = both_q;
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int NPIN        = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPIN-1:0]   bus_wdata,
   output logic [NPIN-1:0]   bus_rdata,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe,
   output logic              irq_lo,
   output logic              irq_hi
);

   localparam int HALF = NPIN / 2;

   generate
      if ((NPIN % 2) != 0 || NPIN < 2 || NPIN > MAX_PINS) begin : g_bad_npin
         $error("gpio_irq_port: NPIN must be even and between 2 and 32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("gpio_irq_port: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NPIN-1:0] pin_sync, pin_prev, hit;
   logic [NPIN-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, both_q, stat_q;
   logic [NPIN-1:0] pend;

   gpio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (pad_in),
      .sync_o (pin_sync),
      .prev_o (pin_prev)
   );

   gpio_trig_detect #(.NPIN(NPIN)) u_detect (
      .sync_i   (pin_sync),
      .prev_i   (pin_prev),
      .cfg_lo_i (cfg_lo_q),
      .cfg_hi_i (cfg_hi_q),
      .both_i   (both_q),
      .hit_o    (hit)
   );

   gpio_regfile #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_lvl_i (pin_sync),
      .hit_i     (hit),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .cfg_lo_q  (cfg_lo_q),
      .cfg_hi_q  (cfg_hi_q),
      .mask_q    (mask_q),
      .both_q    (both_q),
      .stat_q    (stat_q)
   );

   assign pad_out = data_q;
   assign pad_oe  = dir_q;
   assign pend    = stat_q & mask_q;
   assign irq_lo  = |pend[HALF-1:0];
   assign irq_hi  = |pend[NPIN-1:HALF];

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int NPIN        = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPIN-1:0]   bus_wdata,
   input  logic [NPIN-1:0]   pad_in,
   input  logic              irq_lo,
   input  logic              irq_hi,
   input  logic [NPIN-1:0]   sync,
   input  logic [NPIN-1:0]   prev,
   input  logic [NPIN-1:0]   hit,
   input  logic [NPIN-1:0]   cfg_lo,
   input  logic [NPIN-1:0]   cfg_hi,
   input  logic [NPIN-1:0]   both,
   input  logic [NPIN-1:0]   mask,
   input  logic [NPIN-1:0]   stat
);

   localparam int HALF = NPIN / 2;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

   logic [1:0] since_rst;
   logic       clr_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assign clr_wr = bus_we && (bus_addr == A_STAT);

   // R10: nothing unmasked, no interrupt on either line
   p_nomask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> (!irq_lo && !irq_hi));

   // R3: edge history follows the synchronised level
   p_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0) |-> (prev == $past(sync)));

   if (SYNC_STAGES == 2) begin : g_two
      p_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2) |-> (sync == $past(pad_in, 2)));
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic [1:0] code;
      if (p < HALF) begin : g_lo
         assign code = cfg_lo[2*p +: 2];
      end else begin : g_hi
         assign code = cfg_hi[2*(p-HALF) +: 2];
      end

      // R5: a rising edge on a rise-coded pin latches
      p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!both[p] && code == 2'd2 && sync[p] && !prev[p]) |=> stat[p]);

      // R6: both-edges select catches any change
      p_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (both[p] && (sync[p] != prev[p])) |=> stat[p]);

      // R7: clear with no detection empties the bit
      p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && bus_wdata[p] && !hit[p]) |=> !stat[p]);

      // R7: an uncleared bit stays set
      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (stat[p] && !(clr_wr && bus_wdata[p])) |=> stat[p]);

      // R9: detection always wins over a clear
      p_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         hit[p] |=> stat[p]);
   end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
   .NPIN(NPIN), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .pad_in    (pad_in),
   .irq_lo    (irq_lo),
   .irq_hi    (irq_hi),
   .sync      (pin_sync),
   .prev      (pin_prev),
   .hit       (hit),
   .cfg_lo    (cfg_lo_q),
   .cfg_hi    (cfg_hi_q),
   .both      (both_q),
   .mask      (mask_q),
   .stat      (stat_q)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;

   localparam int NPIN   = 32;
   localparam int ADDR_W = 8;

   localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h04, A_PAD = 8'h08,
                          A_CFGL = 8'h0C, A_CFGH = 8'h10, A_MASK = 8'h14,
                          A_STAT = 8'h18, A_BOTH = 8'h1C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [NPIN-1:0]   bus_wdata = '0;
   logic [NPIN-1:0]   bus_rdata;
   logic [NPIN-1:0]   pad_in = '1;
   logic [NPIN-1:0]   pad_out, pad_oe;
   logic              irq_lo, irq_hi;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_irq_port #(.NPIN(NPIN), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_gpio_irq_port (
      .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
      .pad_in, .pad_out, .pad_oe, .irq_lo, .irq_hi
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tidy();
      wr(A_CFGL, '0);
      wr(A_CFGH, '0);
      wr(A_BOTH, '0);
      wr(A_MASK, '0);
      pad_in = '1;
      wait_cyc(4);
      wr(A_STAT, '1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_DATA, v); chk("R11 data", v, 0);
      rd(A_DIR,  v); chk("R11 dir", v, 0);
      rd(A_CFGL, v); chk("R11 cfg lo", v, 0);
      rd(A_CFGH, v); chk("R11 cfg hi", v, 0);
      rd(A_MASK, v); chk("R11 mask", v, 0);
      rd(A_STAT, v); chk("R11 status", v, 0);
      rd(A_BOTH, v); chk("R11 both", v, 0);
      chk("R11 pad_oe", pad_oe, 0);
      chk("R11 irq", {30'd0, irq_hi, irq_lo}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(A_DATA, 32'hA5A5_0F0F);
      wr(A_DIR,  32'hFFFF_0000);
      rd(A_DATA, v); chk("R1 data readback", v, 32'hA5A5_0F0F);
      rd(A_DIR,  v); chk("R1 dir readback", v, 32'hFFFF_0000);
      chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
      chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
      wr(A_CFGL, 32'h1234_5678);
      wr(A_CFGH, 32'h9ABC_DEF0);
      wr(A_MASK, 32'h0F0F_F0F0);
      wr(A_BOTH, 32'h8000_0001);
      rd(A_CFGL, v); chk("R1 cfg lo readback", v, 32'h1234_5678);
      rd(A_CFGH, v); chk("R1 cfg hi readback", v, 32'h9ABC_DEF0);
      rd(A_MASK, v); chk("R1 mask readback", v, 32'h0F0F_F0F0);
      rd(A_BOTH, v); chk("R1 both readback", v, 32'h8000_0001);
      rd(8'h20, v);  chk("R1 unmapped", v, 0);
      wr(A_DIR, '0);
      tidy();
   endtask

   task automatic t_sync();
      logic [31:0] v;
      pad_in = 32'h1234_5678;
      wait_cyc(1);
      rd(A_PAD, v); chk("R3 pad not yet", v, 32'hFFFF_FFFF);
      wait_cyc(1);
      rd(A_PAD, v); chk("R3 pad level", v, 32'h1234_5678);
      tidy();
   endtask

   task automatic t_edges();
      logic [31:0] v;
      wr(A_CFGL, (32'd2 << 4) | (32'd3 << 6));    // pin2 rise, pin3 fall
      wr(A_CFGH, (32'd3 << 8));                   // pin20 fall
      pad_in[2] = 1'b0;
      wait_cyc(4);
      wr(A_STAT, '1);
      rd(A_STAT, v); chk("R5 fall on rise pin ignored", v & 32'h4, 0);
      pad_in[2] = 1'b1;
      wait_cyc(2);
      rd(A_STAT, v); chk("R5 rise not early", v & 32'h4, 0);
      wait_cyc(1);
      rd(A_STAT, v); chk("R5 rise detected", v & 32'h4, 32'h4);
      pad_in[3]  = 1'b0;
      pad_in[20] = 1'b0;
      wait_cyc(3);
      rd(A_STAT, v); chk("R5 fall detected", v & 32'h8, 32'h8);
      chk("R4 upper pin field", v & 32'h0010_0010, 32'h0010_0000);
      tidy();
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(A_CFGL, (32'd1 << 10));                  // pin5 high, pin6 low
      pad_in[6] = 1'b0;
      wait_cyc(3);
      wr(A_STAT, 32'h60);
      rd(A_STAT, v); chk("R8 level held re-sets", v & 32'h60, 32'h60);
      pad_in[5] = 1'b0;
      pad_in[6] = 1'b1;
      wait_cyc(4);
      wr(A_STAT, 32'h60);
      rd(A_STAT, v); chk("R8 level gone clears", v & 32'h60, 0);
      tidy();
   endtask

   task automatic t_clash();
      logic [31:0] v;
      wr(A_CFGL, (32'd2 << 14));                  // pin7 rise
      pad_in[7] = 1'b0;
      wait_cyc(4);
      wr(A_STAT, '1);
      pad_in[7] = 1'b1;
      wait_cyc(2);
      wr(A_STAT, 32'h80);                         // lands with the detection
      rd(A_STAT, v); chk("R9 detection wins", v & 32'h80, 32'h80);
      wr(A_STAT, 32'h80);
      rd(A_STAT, v); chk("R9 later clear works", v & 32'h80, 0);
      tidy();
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(A_CFGL, (32'd2 << 16) | (32'd2 << 18));  // pins 8,9 rise
      pad_in[9:8] = 2'b00;
      wait_cyc(4);
      wr(A_STAT, '1);
      pad_in[9:8] = 2'b11;
      wait_cyc(3);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R7 write zero keeps", v & 32'h300, 32'h300);
      wr(A_STAT, 32'h100);
      rd(A_STAT, v); chk("R7 clear one bit", v & 32'h300, 32'h200);
      wr(A_STAT, '1);
      rd(A_STAT, v); chk("R7 clear all", v, 0);
      tidy();
   endtask

   task automatic t_both();
      logic [31:0] v;
      wr(A_CFGL, (32'd2 << 20));                  // pin10 rise code
      wr(A_BOTH, 32'h400);
      pad_in[10] = 1'b0;
      wait_cyc(3);
      rd(A_STAT, v); chk("R6 falling with both", v & 32'h400, 32'h400);
      wr(A_STAT, 32'h400);
      pad_in[10] = 1'b1;
      wait_cyc(3);
      rd(A_STAT, v); chk("R6 rising with both", v & 32'h400, 32'h400);
      tidy();
   endtask

   task automatic t_irq();
      wr(A_CFGL, (32'd3 << 6));                   // pin3 fall
      wr(A_CFGH, (32'd3 << 8));                   // pin20 fall
      pad_in[3]  = 1'b0;
      pad_in[20] = 1'b0;
      wait_cyc(3);
      chk("R10 all masked", {30'd0, irq_hi, irq_lo}, 0);
      wr(A_MASK, 32'h8);
      #1;
      chk("R10 lower only", {30'd0, irq_hi, irq_lo}, 32'h1);
      wr(A_MASK, 32'h0010_0000);
      #1;
      chk("R10 upper only", {30'd0, irq_hi, irq_lo}, 32'h2);
      wr(A_STAT, 32'h0010_0000);
      #1;
      chk("R10 upper cleared", {30'd0, irq_hi, irq_lo}, 0);
      tidy();
   endtask

   initial begin
      wait_cyc(2);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(4);
      wr(A_STAT, '1);
      t_regs();
      t_sync();
      t_edges();
      t_level();
      t_clash();
      t_w1c();
      t_both();
      t_irq();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule